// File: doc/BRIEF.md
# Two-Stage Compare Watchdog

This block supervises software by comparing a free-running 64-bit system count, supplied as an input, against one absolute deadline register. When the count reaches the deadline while the block is enabled, a timeout fires. The first timeout raises an early-warning output, which is normally wired to an interrupt. A second timeout, with the warning still pending, raises a final output, which is normally wired to a reset request. On every timeout the deadline moves forward by the programmed offset. Because of this, the gap between the warning and the final stage always equals one offset period.

Software sets the deadline in one of two ways. It can write a 32-bit offset, which is added to the current count. It can also write a 64-bit compare value directly, which allows periods longer than the offset can express. A refresh write restarts the offset period. A small register port, with a synchronous write and a combinational read, gives access to enable, offset, compare, refresh and status.

Top module: `wdg_two_stage`

## Requirements
- R1: After reset, warn_o and bite_o are 0, enable is 0, the offset is 0 and the compare register holds all ones.
- R2: While the enable bit (address 0, bit 0) is 0, no timeout occurs. Both outputs are 0 one cycle after any cycle that has enable clear, and the compare register does not change.
- R3: A timeout occurs in a cycle where enable is 1 and sys_count is greater than or equal to the compare register. If warn_o is 0, warn_o rises at that edge and the compare register becomes sys_count plus the offset.
- R4: A timeout while warn_o is 1 sets bite_o to 1, keeps warn_o at 1 and reloads the compare register as sys_count plus the offset. bite_o is never 1 while warn_o is 0.
- R5: Once set, bite_o stays 1 until reset, a refresh, an offset write, a compare write, or a cycle with enable clear. Further timeouts keep reloading the compare register.
- R6: A write to address 3, with any data, clears both outputs and loads the compare register with sys_count plus the offset at the next edge.
- R7: A write to address 1 stores wr_data[31:0] as the offset, clears both outputs, and loads the compare register with sys_count plus the newly written offset.
- R8: A write to address 2 loads all 64 bits of wr_data into the compare register and clears both outputs.
- R9: If a refresh (R6) and a timeout fall in the same cycle, the refresh wins: both outputs become 0 and the reload uses the refresh rule.
- R10: Reads are combinational. Address 0 returns enable in bit 0, address 1 returns the offset zero-extended, address 2 returns the compare register, and address 4 returns warn in bit 0 and bite in bit 1. All other bits and addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_count | input | 64 | Free-running system count |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 64 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 64 | Read data (combinational) |
| warn_o | output | 1 | First-stage timeout |
| bite_o | output | 1 | Second-stage timeout |

## Verification
The collision that matters is a refresh write landing in the very cycle the count reaches the deadline. The bench provokes it by driving sys_count exactly onto the compare value while pulsing the refresh address. The result is judged as correct only when both outputs stay low and the new deadline equals that count plus the offset, rather than a reload from an escalation. A second collision, a disabling control write in a cycle where a timeout is due, checks that the enable in effect during that cycle decides the outcome.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_OFFSET = 3'd1,
        A_CMP    = 3'd2,
        A_KICK   = 3'd3,
        A_STAT   = 3'd4
    } wdg_addr_e;

endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int OFF_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [CNT_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [CNT_W-1:0]    cmp_val,
    input  logic                warn,
    input  logic                bite,
    output logic                en,
    output logic [OFF_W-1:0]    offset,
    output logic [OFF_W-1:0]    eff_offset,
    output logic                reload_req,
    output logic                cmp_wr,
    output logic [CNT_W-1:0]    rd_data
);

    localparam int PAD_W = CNT_W - OFF_W;

    typedef struct packed {
        logic             en;
        logic [OFF_W-1:0] off;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  wr_ctrl, wr_off, wr_kick;

    always_comb begin
        wr_ctrl    = wr_en && (wr_addr == A_CTRL);
        wr_off     = wr_en && (wr_addr == A_OFFSET);
        wr_kick    = wr_en && (wr_addr == A_KICK);
        cmp_wr     = wr_en && (wr_addr == A_CMP);
        reload_req = wr_off || wr_kick;

        regs_d = regs_q;
        if (wr_ctrl) regs_d.en  = wr_data[0];
        if (wr_off)  regs_d.off = wr_data[OFF_W-1:0];

        // an offset write reloads with the value being written
        eff_offset = wr_off ? wr_data[OFF_W-1:0] : regs_q.off;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign en     = regs_q.en;
    assign offset = regs_q.off;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:   rd_data[0] = regs_q.en;
            A_OFFSET: rd_data    = {{PAD_W{1'b0}}, regs_q.off};
            A_CMP:    rd_data    = cmp_val;
            A_STAT:   rd_data[1:0] = {bite, warn};
            default:  rd_data    = '0;
        endcase
    end

    // R7: the offset written is the offset held afterwards
    p_offset_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_off |=> regs_q.off == $past(wr_data[OFF_W-1:0]));

    // R10: only the enable bit reads back at the control address
    p_ctrl_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_CTRL) |-> (rd_data[CNT_W-1:1] == '0));

endmodule

// File: rtl/wdg_deadline.sv
module wdg_deadline #(
    parameter int              CNT_W   = 64,
    parameter int              OFF_W   = 32,
    parameter logic [CNT_W-1:0] CMP_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  sys_count,
    input  logic              en,
    input  logic [OFF_W-1:0]  eff_offset,
    input  logic              reload_req,
    input  logic              cmp_wr,
    input  logic [CNT_W-1:0]  cmp_wdata,
    output logic [CNT_W-1:0]  cmp_val,
    output logic              warn,
    output logic              bite
);

    localparam int PAD_W = CNT_W - OFF_W;

    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic             warn;
        logic             bite;
    } dl_t;

    dl_t              dl_d, dl_q;
    logic             expired;
    logic [CNT_W-1:0] next_deadline;

    always_comb begin
        expired       = en && (sys_count >= dl_q.cmp);
        next_deadline = sys_count + {{PAD_W{1'b0}}, eff_offset};
        dl_d          = dl_q;

        if (reload_req) begin
            // refresh or offset write beats any timeout in this cycle
            dl_d.cmp  = next_deadline;
            dl_d.warn = 1'b0;
            dl_d.bite = 1'b0;
        end else if (cmp_wr) begin
            dl_d.cmp  = cmp_wdata;
            dl_d.warn = 1'b0;
            dl_d.bite = 1'b0;
        end else if (!en) begin
            dl_d.warn = 1'b0;
            dl_d.bite = 1'b0;
        end else if (expired) begin
            dl_d.cmp = next_deadline;
            if (!dl_q.warn) dl_d.warn = 1'b1;
            else            dl_d.bite = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dl_q.cmp  <= CMP_RST;
            dl_q.warn <= 1'b0;
            dl_q.bite <= 1'b0;
        end else begin
            dl_q <= dl_d;
        end
    end

    assign cmp_val = dl_q.cmp;
    assign warn    = dl_q.warn;
    assign bite    = dl_q.bite;

    // R4: the final stage never stands without the warning
    p_bite_needs_warn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dl_q.bite |-> dl_q.warn);

    // R2: a disabled cycle leaves both stages low afterwards
    p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!dl_q.warn && !dl_q.bite));

    // R3: the warning only rises after an enabled cycle at or past the deadline
    p_warn_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dl_q.warn) |-> ($past(en) && ($past(sys_count) >= $past(dl_q.cmp))));

    // R5: bite holds while enabled with no reload or compare write
    p_bite_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_q.bite && en && !reload_req && !cmp_wr) |=> dl_q.bite);

    // R8: a direct compare write lands unchanged
    p_cmp_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr && !reload_req) |=> (dl_q.cmp == $past(cmp_wdata)));

endmodule

// File: rtl/wdg_two_stage.sv
module wdg_two_stage
    import wdg_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int OFF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  sys_count,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              warn_o,
    output logic              bite_o
);

    logic             en;
    logic [OFF_W-1:0] offset;
    logic [OFF_W-1:0] eff_offset;
    logic             reload_req;
    logic             cmp_wr;
    logic [CNT_W-1:0] cmp_val;
    logic             warn, bite;

    wdg_regs #(.CNT_W(CNT_W), .OFF_W(OFF_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .cmp_val    (cmp_val),
        .warn       (warn),
        .bite       (bite),
        .en         (en),
        .offset     (offset),
        .eff_offset (eff_offset),
        .reload_req (reload_req),
        .cmp_wr     (cmp_wr),
        .rd_data    (rd_data)
    );

    wdg_deadline #(.CNT_W(CNT_W), .OFF_W(OFF_W)) u_deadline (
        .clk        (clk),
        .rst_n      (rst_n),
        .sys_count  (sys_count),
        .en         (en),
        .eff_offset (eff_offset),
        .reload_req (reload_req),
        .cmp_wr     (cmp_wr),
        .cmp_wdata  (wr_data),
        .cmp_val    (cmp_val),
        .warn       (warn),
        .bite       (bite)
    );

    assign warn_o = warn;
    assign bite_o = bite;

    // R6 / R9: a refresh clears both stages even if a timeout was due
    p_kick_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_KICK) |=> (!warn_o && !bite_o));

    // R6: a refresh reloads from the count and the held offset
    p_kick_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_KICK) |=>
        (cmp_val == $past(sys_count) + {{(CNT_W-OFF_W){1'b0}}, $past(offset)}));

    // R10: the status address mirrors the stage outputs
    p_status_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_STAT) |-> (rd_data[1:0] == {bite_o, warn_o}));

endmodule

// File: tb/wdg_two_stage_tb_top.sv
module wdg_two_stage_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] sys_count = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [63:0] rd_data;
    logic        warn_o, bite_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #10 clk = ~clk;  // 50 MHz

    wdg_two_stage dut_i (
        .clk(clk), .rst_n(rst_n), .sys_count(sys_count),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .warn_o(warn_o), .bite_o(bite_o)
    );

    typedef struct packed {
        logic        we;
        logic [2:0]  addr;
        logic [63:0] data;
        logic [63:0] cnt;
        logic        ew;
        logic        eb;
        logic [63:0] ecmp;
        logic [3:0]  req;
    } vec_t;

    localparam logic [63:0] ONES = '1;

    localparam vec_t VEC [18] = '{
        '{1'b1, 3'd0, 64'd1,          64'd0,    1'b0, 1'b0, ONES,     4'd2},  // R2 enable on
        '{1'b1, 3'd1, 64'd100,        64'd10,   1'b0, 1'b0, 64'd110,  4'd7},  // R7 offset write
        '{1'b0, 3'd0, 64'd0,          64'd109,  1'b0, 1'b0, 64'd110,  4'd3},  // R3 below deadline
        '{1'b0, 3'd0, 64'd0,          64'd110,  1'b1, 1'b0, 64'd210,  4'd3},  // R3 equal -> warn
        '{1'b0, 3'd0, 64'd0,          64'd150,  1'b1, 1'b0, 64'd210,  4'd4},  // R4 waiting
        '{1'b0, 3'd0, 64'd0,          64'd215,  1'b1, 1'b1, 64'd315,  4'd4},  // R4 past -> bite
        '{1'b0, 3'd0, 64'd0,          64'd400,  1'b1, 1'b1, 64'd500,  4'd5},  // R5 stays set
        '{1'b1, 3'd3, 64'd0,          64'd420,  1'b0, 1'b0, 64'd520,  4'd6},  // R6 refresh
        '{1'b0, 3'd0, 64'd0,          64'd520,  1'b1, 1'b0, 64'd620,  4'd3},  // R3 again
        '{1'b1, 3'd2, 64'd1000,       64'd600,  1'b0, 1'b0, 64'd1000, 4'd8},  // R8 compare write
        '{1'b0, 3'd0, 64'd0,          64'd999,  1'b0, 1'b0, 64'd1000, 4'd8},  // R8 holds
        '{1'b1, 3'd3, 64'd0,          64'd1000, 1'b0, 1'b0, 64'd1100, 4'd9},  // R9 refresh wins
        '{1'b1, 3'd0, 64'd0,          64'd1100, 1'b1, 1'b0, 64'd1200, 4'd2},  // R2 old enable still live
        '{1'b0, 3'd0, 64'd0,          64'd5000, 1'b0, 1'b0, 64'd1200, 4'd2},  // R2 disabled clears
        '{1'b0, 3'd0, 64'd0,          64'd6000, 1'b0, 1'b0, 64'd1200, 4'd2},  // R2 no timeout
        '{1'b1, 3'd0, 64'd1,          64'd1150, 1'b0, 1'b0, 64'd1200, 4'd2},  // R2 re-enable
        '{1'b1, 3'd1, 64'h1_0000_0005, 64'd2000, 1'b0, 1'b0, 64'd2005, 4'd7}, // R7 low 32 bits
        '{1'b0, 3'd0, 64'd0,          64'd2005, 1'b1, 1'b0, 64'd2010, 4'd3}   // R3 short offset
    };

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [2:0] addr,
                        input logic [63:0] data, input logic [63:0] cnt);
        @(negedge clk);
        wr_en = we; wr_addr = addr; wr_data = data; sys_count = cnt;
        @(posedge clk);
        #2;
        wr_en = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        string tag;
        #35;
        // R1 reset state
        rd_addr = 3'd4; #1;
        check("R1", "warn", {63'd0, warn_o}, 64'd0);
        check("R1", "bite", {63'd0, bite_o}, 64'd0);
        check("R1", "status", rd_data, 64'd0);
        rst_n = 1'b1;
        rd_addr = 3'd0; #1;
        check("R1", "enable", rd_data, 64'd0);
        rd_addr = 3'd1; #1;
        check("R1", "offset", rd_data, 64'd0);
        rd_addr = 3'd2; #1;
        check("R1", "compare", rd_data, ONES);

        for (int i = 0; i < 18; i++) begin
            step(VEC[i].we, VEC[i].addr, VEC[i].data, VEC[i].cnt);
            rd_addr = 3'd2; #1;
            tag = $sformatf("R%0d", VEC[i].req);
            check(tag, $sformatf("v%0d warn", i), {63'd0, warn_o}, {63'd0, VEC[i].ew});
            check(tag, $sformatf("v%0d bite", i), {63'd0, bite_o}, {63'd0, VEC[i].eb});
            check(tag, $sformatf("v%0d cmp", i), rd_data, VEC[i].ecmp);
        end

        // R10 readback after the table
        rd_addr = 3'd1; #1;
        check("R10", "offset read", rd_data, 64'd5);
        rd_addr = 3'd0; #1;
        check("R10", "ctrl read", rd_data, 64'd1);
        rd_addr = 3'd4; #1;
        check("R10", "status warn", rd_data, 64'd1);
        rd_addr = 3'd6; #1;
        check("R10", "unused addr", rd_data, 64'd0);

        // R5 bite sticky, then R2 disable clears it
        step(1'b0, 3'd0, 64'd0, 64'd2010);
        step(1'b0, 3'd0, 64'd0, 64'd2012);
        rd_addr = 3'd4; #1;
        check("R10", "status both", rd_data, 64'd3);
        step(1'b0, 3'd0, 64'd0, 64'd2013);
        check("R5", "bite held", {63'd0, bite_o}, 64'd1);
        step(1'b1, 3'd0, 64'd0, 64'd2013);
        check("R5", "bite held on disable edge", {63'd0, bite_o}, 64'd1);
        step(1'b0, 3'd0, 64'd0, 64'd2013);
        check("R2", "bite cleared", {63'd0, bite_o}, 64'd0);
        check("R2", "warn cleared", {63'd0, warn_o}, 64'd0);

        // R1 reset mid-run restores defaults
        step(1'b1, 3'd0, 64'd1, 64'd3000);
        step(1'b0, 3'd0, 64'd0, 64'd9000);
        check("R3", "warn pre-reset", {63'd0, warn_o}, 64'd1);
        rst_n = 1'b0; #1;
        rd_addr = 3'd2; #1;
        check("R1", "warn async reset", {63'd0, warn_o}, 64'd0);
        check("R1", "compare async reset", rd_data, ONES);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule